// File: doc/BRIEF.md
# Processor Sleep Clock-Request Controller

This block sits beside a processor core and decides, each time the core goes to sleep, whether the system-level clock request may be released. The core reports a sleep entry together with a deep-sleep flag, and later a wakeup event. In the default setting every sleep releases the clock request. A light-sleep option keeps clocks requested across shallow sleeps so the core wakes faster. Deep sleeps always release the request. When clocks were released, the block re-requests them at once on wakeup and holds the core's resume strobe back by a fixed re-enable latency.

A small control register on an APB port holds the light-sleep enable and a request that the next deep sleep use the wake-interrupt controller (WIC). A read-only acknowledge bit shows the controller's answer. The request is driven out of the block. The acknowledge input is accepted only when it agrees with the request, so the status bit never moves on its own. Software writes the request, polls the acknowledge and then sleeps. A deep sleep that starts while both are set is flagged as a WIC sleep until the wakeup.

Top module: `sleep_clkreq_ctrl`

## Requirements
- R1: After reset, the control register at byte offset 0x8 reads 0x2 (bit 0 light-sleep = 0, bit 1 WIC request = 1, bit 2 acknowledge = 0) as long as the acknowledge input has stayed low. The clock request output is 1, the resume strobe is 0 and the WIC request output is 1.
- R2: With light-sleep = 0, a shallow sleep-entry pulse sampled while running drops the clock request from the next cycle on.
- R3: With light-sleep = 1, a shallow sleep-entry pulse leaves the clock request at 1 for the whole sleep.
- R4: A deep sleep-entry pulse drops the clock request from the next cycle on, whatever the light-sleep bit holds.
- R5: A wakeup sampled during a sleep that dropped the clock request raises the clock request in the next cycle. The one-cycle resume strobe follows WAKE_LAT (5) cycles later than it would in R6.
- R6: A wakeup sampled during a sleep that kept the clock request gives a one-cycle resume strobe in the next cycle.
- R7: Bit 2 (acknowledge) takes the acknowledge input's value only when that value equals the current WIC request. It therefore lags a request change and never changes without a matching request. APB writes to bit 2 have no effect.
- R8: A deep sleep entered while the WIC request and the acknowledge are both 1 drives the WIC-sleep output high until wakeup. A shallow sleep, or a deep sleep with either bit at 0, leaves that output low.
- R9: Bits 31..3 of the control register read 0 and ignore writes. Any other offset reads 0, and writes to it change nothing.
- R10: Every APB access completes with no wait state: PREADY is 1 and PSLVERR is 0.
- R11: A sleep-entry pulse while already asleep or waking has no effect. A wakeup pulse while running, or during the re-enable wait, produces no extra resume strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error, always 0 |
| slp_enter | input | 1 | One-cycle pulse: the core enters sleep |
| slp_deep | input | 1 | Deep-sleep flag, sampled with slp_enter |
| wake_evt | input | 1 | One-cycle wakeup event |
| wic_ack_in | input | 1 | Acknowledge from the wake-interrupt controller |
| clk_req | output | 1 | System-level clock request |
| core_resume | output | 1 | One-cycle strobe: the core may resume |
| wic_en_req | output | 1 | WIC enable request toward the controller |
| wic_sleep | output | 1 | The current sleep is a WIC sleep |

## Verification
Sleeps are entered with each combination that matters: shallow with light-sleep off, shallow with it on, and deep with it on, with the WIC request set and cleared. The cases separate a kept clock request from a dropped one and a WIC sleep from a plain one. The resume strobe is predicted per wakeup and matched against its arrival cycle, so the kept and re-enabled paths are told apart by exactly the re-enable latency. The acknowledge path runs with a delayed stub and with a stub that disagrees with the request, which separates a correct lag from an acknowledge that moves with no request behind it. Extra entry and wake pulses during sleep, during the wait and while running check that they add no strobe and change no state.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    localparam int CTRL_LIGHT_BIT = 0;
    localparam int CTRL_WREQ_BIT  = 1;
    localparam int CTRL_WACK_BIT  = 2;
    localparam int CTRL_USED_W    = 3;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_KEEP  = 2'd1,
        ST_GATED = 2'd2,
        ST_WAIT  = 2'd3
    } slp_state_e;

    typedef struct packed {
        logic light;
        logic wreq;
        logic wack;
    } ctrl_t;

endpackage

// File: rtl/sclk_regs.sv
module sclk_regs
    import sclk_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 32,
    parameter logic [11:0] CTRL_OFF = 12'h008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic              wic_ack_i,
    output logic [DATA_W-1:0] prdata,
    output logic              light_o,
    output logic              wreq_o,
    output logic              wack_o
);

    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(CTRL_OFF);

    ctrl_t r_d, r_q;
    logic  wr_hit, rd_hit;
    logic  unused_wdata;

    assign unused_wdata = ^pwdata;

    always_comb begin
        r_d    = r_q;
        wr_hit = psel && penable && pwrite && (paddr == OFF);
        rd_hit = psel && !pwrite && (paddr == OFF);
        if (wr_hit) begin
            r_d.light = pwdata[CTRL_LIGHT_BIT];
            r_d.wreq  = pwdata[CTRL_WREQ_BIT];
        end
        // acknowledge is accepted only when it agrees with the request
        if (wic_ack_i == r_q.wreq) begin
            r_d.wack = wic_ack_i;
        end
        prdata = '0;
        if (rd_hit) begin
            prdata[CTRL_LIGHT_BIT] = r_q.light;
            prdata[CTRL_WREQ_BIT]  = r_q.wreq;
            prdata[CTRL_WACK_BIT]  = r_q.wack;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{light: 1'b0, wreq: 1'b1, wack: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign light_o = r_q.light;
    assign wreq_o  = r_q.wreq;
    assign wack_o  = r_q.wack;

    // R7: the acknowledge only ever moves to the value the request held
    a_r7_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.wack) |-> (r_q.wack == $past(r_q.wreq)));

    // R9: unused register bits always read as zero
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        prdata[DATA_W-1:CTRL_USED_W] == '0);

endmodule

// File: rtl/sclk_seq.sv
module sclk_seq
    import sclk_pkg::*;
#(
    parameter int WAKE_LAT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_i,
    input  logic deep_i,
    input  logic wake_i,
    input  logic light_i,
    input  logic wreq_i,
    input  logic wack_i,
    output logic clk_req_o,
    output logic resume_o,
    output logic wic_sleep_o
);

    localparam int CNT_W = (WAKE_LAT < 2) ? 1 : $clog2(WAKE_LAT);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAKE_LAT - 1);

    typedef struct packed {
        slp_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             resume;
        logic             wic;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.resume = 1'b0;
        unique case (s_q.state)
            ST_RUN: begin
                if (enter_i) begin
                    if (deep_i || !light_i) begin
                        s_d.state = ST_GATED;
                    end else begin
                        s_d.state = ST_KEEP;
                    end
                    s_d.wic = deep_i && wreq_i && wack_i;
                end
            end
            ST_KEEP: begin
                if (wake_i) begin
                    s_d.state  = ST_RUN;
                    s_d.resume = 1'b1;
                end
            end
            ST_GATED: begin
                if (wake_i) begin
                    s_d.state = ST_WAIT;
                    s_d.cnt   = CNT_LOAD;
                    s_d.wic   = 1'b0;
                end
            end
            ST_WAIT: begin
                if (s_q.cnt == '0) begin
                    s_d.state  = ST_RUN;
                    s_d.resume = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_RUN, cnt: '0, resume: 1'b0, wic: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign clk_req_o   = (s_q.state != ST_GATED);
    assign resume_o    = s_q.resume;
    assign wic_sleep_o = s_q.wic;

    // R2 / R4: a releasing entry drops the clock request in the next cycle
    a_r2_r4_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_RUN && enter_i && (deep_i || !light_i)) |=> !clk_req_o);

    // R3: shallow entry with light-sleep keeps clocks requested
    a_r3_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_RUN && enter_i && !deep_i && light_i) |=> clk_req_o);

    // R5: clock request first, resume held back
    a_r5_clk_first: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_GATED && wake_i) |=> (clk_req_o && !resume_o));

    // R6: kept-clock wake resumes at once
    a_r6_fast_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_KEEP && wake_i) |=> resume_o);

    // R6: resume is a single-cycle strobe
    a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |=> !resume_o);

    // R11: no resume strobe follows a cycle spent running
    a_r11_run_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_RUN) |=> !resume_o);

    // R8: a WIC sleep is always a released-clock sleep
    a_r8_wic_gated: assert property (@(posedge clk) disable iff (!rst_n)
        wic_sleep_o |-> !clk_req_o);

endmodule

// File: rtl/sleep_clkreq_ctrl.sv
module sleep_clkreq_ctrl
    import sclk_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 32,
    parameter logic [11:0] CTRL_OFF = 12'h008,
    parameter int          WAKE_LAT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              slp_enter,
    input  logic              slp_deep,
    input  logic              wake_evt,
    input  logic              wic_ack_in,
    output logic              clk_req,
    output logic              core_resume,
    output logic              wic_en_req,
    output logic              wic_sleep
);

    logic light_q, wreq_q, wack_q;

    sclk_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CTRL_OFF (CTRL_OFF)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .wic_ack_i (wic_ack_in),
        .prdata    (prdata),
        .light_o   (light_q),
        .wreq_o    (wreq_q),
        .wack_o    (wack_q)
    );

    sclk_seq #(
        .WAKE_LAT (WAKE_LAT)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_i     (slp_enter),
        .deep_i      (slp_deep),
        .wake_i      (wake_evt),
        .light_i     (light_q),
        .wreq_i      (wreq_q),
        .wack_i      (wack_q),
        .clk_req_o   (clk_req),
        .resume_o    (core_resume),
        .wic_sleep_o (wic_sleep)
    );

    assign wic_en_req = wreq_q;
    assign pready     = 1'b1;
    assign pslverr    = 1'b0;

    // R10: zero-wait, error-free bus
    a_r10_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        psel |-> (pready && !pslverr));

endmodule

// File: tb/sleep_clkreq_ctrl_bench.sv
module sleep_clkreq_ctrl_bench;

    localparam int          LAT  = 5;
    localparam logic [11:0] CTRL = 12'h008;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        slp_enter = 1'b0, slp_deep = 1'b0, wake_evt = 1'b0;
    logic        ack_in;
    logic        clk_req, core_resume, wic_en_req, wic_sleep;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int n_resume = 0;
    int exp_q[$];
    int ack_delay = 20;
    int dcnt;
    bit stub_bad = 1'b0;

    always #2.5 clk = ~clk;

    sleep_clkreq_ctrl u_sleep_clkreq_ctrl (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .slp_enter(slp_enter), .slp_deep(slp_deep),
        .wake_evt(wake_evt), .wic_ack_in(ack_in), .clk_req(clk_req),
        .core_resume(core_resume), .wic_en_req(wic_en_req), .wic_sleep(wic_sleep)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // interrupt-controller stub: follows the request after ack_delay cycles
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_in <= 1'b0;
            dcnt   <= 0;
        end else if (stub_bad) begin
            ack_in <= ~wic_en_req;
        end else if (ack_in != wic_en_req) begin
            if (dcnt >= ack_delay) begin
                ack_in <= wic_en_req;
                dcnt   <= 0;
            end else begin
                dcnt <= dcnt + 1;
            end
        end else begin
            dcnt <= 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: every resume strobe must match a predicted cycle
    always @(negedge clk) begin
        if (rst_n && core_resume) begin
            n_resume++;
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R11: actual=resume at cycle %0d expected=no resume", cyc);
            end else begin
                check("R5/R6 resume cycle", cyc, exp_q.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected=done", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        d = prdata;
        check("R10 ready/error", {30'b0, pready, pslverr}, 32'h2);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic wait_ack(input logic v);
        logic [31:0] d;
        for (int i = 0; i < 60; i++) begin
            apb_read(CTRL, d);
            if (d[2] == v) break;
        end
    endtask

    // drive a sleep entry; the clock request is checked in the next cycle
    task automatic do_sleep(input logic deep, input logic kept, input logic wic, input string req);
        @(negedge clk);
        slp_enter = 1'b1; slp_deep = deep;
        @(negedge clk);
        slp_enter = 1'b0; slp_deep = 1'b0;
        check(req, clk_req, kept);
        check("R8 wic sleep", wic_sleep, wic);
    endtask

    // driver: pushes the predicted resume cycle, then pulses the wake event
    task automatic do_wake(input logic kept);
        @(negedge clk);
        wake_evt = 1'b1;
        exp_q.push_back(cyc + 1 + (kept ? 0 : LAT));
        @(negedge clk);
        wake_evt = 1'b0;
        check("R5 clk_req back after wake", clk_req, 1'b1);
        check("R8 wic sleep cleared", wic_sleep, 1'b0);
    endtask

    initial begin
        logic [31:0] d;
        int base;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 clk_req", clk_req, 1'b1);
        check("R1 resume", core_resume, 1'b0);
        check("R1 wic_en_req", wic_en_req, 1'b1);
        apb_read(CTRL, d);
        check("R1 ctrl reset", d, 32'h2);
        // R7 acknowledge arrives after the stub delay
        wait_ack(1'b1);
        apb_read(CTRL, d);
        check("R7 ack set", d, 32'h6);
        // R7 lag: clear request, ack still 1; write to bit 2 ignored
        apb_write(CTRL, 32'h0000_0005);
        apb_read(CTRL, d);
        check("R7 ack lags request", d, 32'h5);
        wait_ack(1'b0);
        apb_read(CTRL, d);
        check("R7 ack follows clear", d, 32'h1);
        // R9 / R7 upper bits and ack bit not writable
        apb_write(CTRL, 32'hFFFF_FFF8);
        apb_read(CTRL, d);
        check("R9 upper bits zero", d, 32'h0);
        apb_write(CTRL, 32'h3);
        wait_ack(1'b1);
        apb_read(CTRL, d);
        check("R7 ack after request", d, 32'h7);
        // R7 ack never moves without a request change
        stub_bad = 1'b1;
        idle(10);
        apb_read(CTRL, d);
        check("R7 ack ignores disagreeing input", d, 32'h7);
        stub_bad = 1'b0;
        idle(25);
        // R9 other offsets
        apb_write(12'h000, 32'hFFFF_FFFF);
        apb_read(12'h000, d);
        check("R9 other offset reads 0", d, 32'h0);
        apb_read(12'h004, d);
        check("R9 offset 4 reads 0", d, 32'h0);
        apb_read(CTRL, d);
        check("R9 ctrl unchanged", d, 32'h7);

        // R3 / R6 light-sleep shallow sleep keeps clocks
        do_sleep(1'b0, 1'b1, 1'b0, "R3 kept clock request");
        idle(4);
        check("R3 still requested", clk_req, 1'b1);
        do_wake(1'b1);
        idle(3);
        // R4 / R8 / R11 deep sleep with light on, WIC armed
        do_sleep(1'b1, 1'b0, 1'b1, "R4 deep drops clock");
        @(negedge clk);
        slp_enter = 1'b1; slp_deep = 1'b0;
        @(negedge clk);
        slp_enter = 1'b0;
        idle(2);
        check("R11 entry while asleep ignored", clk_req, 1'b0);
        check("R11 wic sleep kept", wic_sleep, 1'b1);
        do_wake(1'b0);
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
        idle(LAT + 3);
        // R2 default shallow sleep drops clocks
        apb_write(CTRL, 32'h2);
        do_sleep(1'b0, 1'b0, 1'b0, "R2 default drops clock");
        do_wake(1'b0);
        idle(LAT + 3);
        // R8 deep sleep with request cleared is not a WIC sleep
        apb_write(CTRL, 32'h0);
        wait_ack(1'b0);
        do_sleep(1'b1, 1'b0, 1'b0, "R4 deep drops clock");
        do_wake(1'b0);
        idle(LAT + 3);
        // R11 wake while running
        base = n_resume;
        @(negedge clk);
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
        idle(8);
        check("R11 no resume while running", n_resume, base);
        check("R11 clk_req while running", clk_req, 1'b1);
        check("R5 all resumes seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule